// File: doc/BRIEF.md
# L1 Trigger Gating Controller

The block turns level-1 trigger pulses into the serial trigger-command stream of a multi-sample analog front-end chip. Every trigger it accepts becomes two back-to-back three-bit trigger symbols, each the bit sequence 1,0,0. The pair asks the chip for six samples along the shaped pulse. The block refuses any trigger that would break one of the chip's two rules. One rule is a minimum spacing between accepted triggers. The other is a cap on how many samples may wait in the chip's pending-sample FIFO.

The block tracks that FIFO with its own fill model. The model rises by six on each accepted trigger and falls by three on each readout-complete pulse, since one frame is read per symbol. Saturating counters report accepted triggers and the two kinds of rejection. They are separate so that dead time can be split by cause.

Top module: `l1_trig_gate`

## Requirements
- R1: While rst_ni is low, and after it is released, cmd_o, fill_o and all three counters are 0.
- R2: A trigger accepted at clock edge t drives cmd_o to 1,0,0,1,0,0 over the six cycles after edge t. cmd_o is 0 at every other time.
- R3: A trigger sampled 1 to 5 edges after the last accepted trigger is rejected and increments lost_gap_o. A trigger exactly 6 edges later is accepted. A rejected trigger does not restart the spacing window.
- R4: Each accepted trigger raises fill_o by 6. fill_o never exceeds 32.
- R5: A trigger whose acceptance would lift the fill above 32 is rejected and increments lost_full_o. The check uses the fill value held before that edge.
- R6: A trigger that breaks both rules increments lost_gap_o only.
- R7: Each rdo_done_i pulse lowers fill_o by 3, clamped at 0. A pulse on the same edge as an accepted trigger gives a net rise of 3.
- R8: acc_cnt_o counts accepted triggers.
- R9: All three counters hold at their maximum value (all ones) and never wrap.
- R10: A rejected trigger leaves cmd_o and fill_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_i | input | 1 | Level-1 trigger request, one per high cycle |
| rdo_done_i | input | 1 | One frame readout completed |
| cmd_o | output | 1 | Serial trigger-command bit |
| fill_o | output | $clog2(FIFO_DEPTH+1) | Modelled pending-sample count |
| acc_cnt_o | output | CNT_W | Accepted trigger count |
| lost_gap_o | output | CNT_W | Triggers lost to spacing |
| lost_full_o | output | CNT_W | Triggers lost to FIFO fill |

## Verification
The assertions assume that rdo_done_i never reports more frames than were requested. If it did, the model would have to clamp, and the step bound on fill_o would still hold. The assertions also assume l1_i is synchronous and sampled once per edge.

The stimulus pulses rdo_done_i only when the model holds at least 3, except for one deliberate pulse at zero that exercises the clamp. Triggers are placed at exact edge offsets, so each spacing case lands where intended.

// File: rtl/l1g_pkg.sv
package l1g_pkg;
  localparam int SYM_BITS        = 3;
  localparam logic [SYM_BITS-1:0] SYM_PATTERN = 3'b100;
  localparam int SAMPLES_PER_SYM = 3;

  typedef struct packed {
    logic acc;
    logic lost_gap;
    logic lost_full;
  } trig_ev_t;
endpackage

// File: rtl/l1g_sym_ser.sv
module l1g_sym_ser #(
  parameter int SYMS_PER_TRIG = 2,
  parameter int MIN_GAP       = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic cmd_o,
  output logic too_close_o
);
  import l1g_pkg::*;
  localparam int SR_W  = SYM_BITS * SYMS_PER_TRIG;
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);

  logic [SR_W-1:0]  sr_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      gap_q <= '0;
    end else if (accept_i) begin
      sr_q  <= {SYMS_PER_TRIG{SYM_PATTERN}};
      gap_q <= GAP_LOAD;
    end else begin
      sr_q  <= {sr_q[SR_W-2:0], 1'b0};
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign cmd_o       = sr_q[SR_W-1];
  assign too_close_o = (gap_q != '0);
endmodule

// File: rtl/l1g_fill_model.sv
module l1g_fill_model #(
  parameter int FIFO_DEPTH    = 32,
  parameter int SYMS_PER_TRIG = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            accept_i,
  input  logic                            done_i,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fill_o,
  output logic                            room_o
);
  import l1g_pkg::*;
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
  localparam int SUM_W  = FILL_W + 1;
  localparam logic [SUM_W-1:0] STEP_UP = SUM_W'(SYMS_PER_TRIG * SAMPLES_PER_SYM);
  localparam logic [SUM_W-1:0] STEP_DN = SUM_W'(SAMPLES_PER_SYM);
  localparam logic [SUM_W-1:0] CAP     = SUM_W'(FIFO_DEPTH);

  logic [FILL_W-1:0] fill_q;
  logic [SUM_W-1:0]  raised, nxt;

  always_comb begin
    raised = {1'b0, fill_q} + (accept_i ? STEP_UP : '0);
    nxt    = raised;
    if (done_i) nxt = (raised >= STEP_DN) ? raised - STEP_DN : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= nxt[FILL_W-1:0];
  end

  assign room_o = ({1'b0, fill_q} + STEP_UP) <= CAP;
  assign fill_o = fill_q;
endmodule

// File: rtl/l1g_sat_cnt.sv
module l1g_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/l1_trig_gate.sv
module l1_trig_gate #(
  parameter int MIN_GAP       = 6,
  parameter int FIFO_DEPTH    = 32,
  parameter int SYMS_PER_TRIG = 2,
  parameter int CNT_W         = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            l1_i,
  input  logic                            rdo_done_i,
  output logic                            cmd_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fill_o,
  output logic [CNT_W-1:0]                acc_cnt_o,
  output logic [CNT_W-1:0]                lost_gap_o,
  output logic [CNT_W-1:0]                lost_full_o
);
  import l1g_pkg::*;
  localparam int N_CNT = $bits(trig_ev_t);

  logic     too_close, has_room;
  trig_ev_t ev;
  logic [N_CNT-1:0]            ev_bits;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  // spacing loss takes precedence over fill loss
  always_comb begin
    ev.acc       = l1_i & ~too_close & has_room;
    ev.lost_gap  = l1_i & too_close;
    ev.lost_full = l1_i & ~too_close & ~has_room;
  end
  assign ev_bits = ev;

  l1g_sym_ser #(.SYMS_PER_TRIG(SYMS_PER_TRIG), .MIN_GAP(MIN_GAP)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(ev.acc),
    .cmd_o(cmd_o), .too_close_o(too_close)
  );

  l1g_fill_model #(.FIFO_DEPTH(FIFO_DEPTH), .SYMS_PER_TRIG(SYMS_PER_TRIG)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(ev.acc), .done_i(rdo_done_i),
    .fill_o(fill_o), .room_o(has_room)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    l1g_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ev_bits[g]), .cnt_o(cnt[g])
    );
  end

  assign acc_cnt_o   = cnt[2];
  assign lost_gap_o  = cnt[1];
  assign lost_full_o = cnt[0];
endmodule

// File: rtl/l1_trig_gate_chk.sv
module l1_trig_gate_chk #(
  parameter int FIFO_DEPTH    = 32,
  parameter int SYMS_PER_TRIG = 2,
  parameter int CNT_W         = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cmd_o,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fill_o,
  input logic [CNT_W-1:0]                acc_cnt_o,
  input logic [CNT_W-1:0]                lost_gap_o,
  input logic [CNT_W-1:0]                lost_full_o
);
  localparam int UP = SYMS_PER_TRIG * 3;

  p_cmd_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |=> !cmd_o);

  p_fill_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_o) <= FIFO_DEPTH);

  p_fill_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_o) <= int'($past(fill_o)) + UP);

  p_gap_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_gap_o != $past(lost_gap_o)) |-> (lost_full_o == $past(lost_full_o)));

  p_acc_emits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt_o != $past(acc_cnt_o)) |-> cmd_o);

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt_o >= $past(acc_cnt_o)) && (lost_gap_o >= $past(lost_gap_o))
    && (lost_full_o >= $past(lost_full_o)));
endmodule

bind l1_trig_gate l1_trig_gate_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .SYMS_PER_TRIG(SYMS_PER_TRIG), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .fill_o(fill_o),
  .acc_cnt_o(acc_cnt_o), .lost_gap_o(lost_gap_o), .lost_full_o(lost_full_o)
);

// File: tb/l1_trig_gate_bench.sv
`timescale 1ns/1ps
module l1_trig_gate_bench;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l1 = 1'b0;
  logic done = 1'b0;
  logic cmd;
  logic [5:0] fill;
  logic [CW-1:0] acc, lgap, lfull;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  l1_trig_gate #(.CNT_W(CW)) u_l1_trig_gate (
    .clk_i(clk), .rst_ni(rst_n), .l1_i(l1), .rdo_done_i(done),
    .cmd_o(cmd), .fill_o(fill), .acc_cnt_o(acc),
    .lost_gap_o(lgap), .lost_full_o(lfull)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig();
    l1 = 1'b1; @(negedge clk); l1 = 1'b0;
  endtask

  task automatic rdo();
    done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; l1 = 1'b0; done = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  // called right after trig(); consumes 5 more cycles
  task automatic chk_stream(input string req);
    chk(req, cmd, 1);
    idle(1); chk(req, cmd, 0);
    idle(1); chk(req, cmd, 0);
    idle(1); chk(req, cmd, 1);
    idle(1); chk(req, cmd, 0);
    idle(1); chk(req, cmd, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(1);
    chk("R1 cmd in reset", cmd, 0);
    chk("R1 fill in reset", fill, 0);
    do_reset();
    chk("R1 cmd", cmd, 0);
    chk("R1 fill", fill, 0);
    chk("R1 acc", acc, 0);
    chk("R1 lost_gap", lgap, 0);
    chk("R1 lost_full", lfull, 0);
  endtask

  task automatic t_single();
    do_reset();
    trig();
    chk_stream("R2 stream");
    chk("R4 fill after one", fill, 6);
    chk("R8 acc one", acc, 1);
    idle(3);
    chk("R2 idle zero", cmd, 0);
  endtask

  task automatic t_spacing();
    do_reset();
    trig();            // edge t
    idle(4);
    trig();            // edge t+5: too close
    chk("R3 lost_gap", lgap, 1);
    chk("R10 fill kept", fill, 6);
    trig();            // edge t+6: accepted
    chk_stream("R3 stream after gap");
    chk("R3 acc", acc, 2);
    chk("R4 fill two", fill, 12);
    chk("R3 no full loss", lfull, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 5; i++) begin trig(); idle(5); end
    chk("R4 fill 30", fill, 30);
    trig();
    chk("R5 lost_full", lfull, 1);
    chk("R10 cmd quiet", cmd, 0);
    chk("R10 fill held", fill, 30);
    rdo();
    chk("R7 fill 27", fill, 27);
    trig();
    chk("R5 reject at 27", lfull, 2);
    rdo();
    chk("R7 fill 24", fill, 24);
    trig();
    chk("R5 accept at 24", fill, 30);
    chk("R8 acc six", acc, 6);
    idle(1);
    trig();            // too close and no room
    chk("R6 gap counted", lgap, 1);
    chk("R6 full untouched", lfull, 2);
  endtask

  task automatic t_readout();
    do_reset();
    rdo();
    chk("R7 clamp zero", fill, 0);
    trig();
    idle(5);
    l1 = 1'b1; done = 1'b1; @(negedge clk); l1 = 1'b0; done = 1'b0;
    chk("R7 net plus three", fill, 9);
    rdo();
    chk("R7 minus three", fill, 6);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 9; i++) begin trig(); rdo(); rdo(); idle(3); end
    chk("R9 acc saturates", acc, 7);
    chk("R9 fill back", fill, 0);
    do_reset();
    l1 = 1'b1; idle(12); l1 = 1'b0;
    chk("R9 lost_gap saturates", lgap, 7);
    chk("R9 acc two", acc, 2);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_spacing();
    t_full();
    t_readout();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule